// File: doc/BRIEF.md
# SDI Preamble Sync-Bit Inserter and Remover

This block conditions the timing reference sequence (TRS) preamble of a 10-bit multiplexed serial digital video stream. In that stream, chroma and luma words alternate in groups of four. Each preamble position therefore appears as eight consecutive words: eight all-ones words, then sixteen all-zeros words, then eight XYZ words. Sent as is, the stream would contain very long runs of identical bits.

The transmit path rewrites the preamble so that the serialized stream has bounded runs. It keeps exactly one all-ones word followed by two all-zeros words, which is the pattern a receiver locks onto for word framing. The receive path undoes the rewrite so that downstream logic sees the standard preamble again.

Both paths share a clock and a clock enable. Each path takes a word and a flag that marks the first word of every EAV and SAV TRS. Each path returns the processed word and a delayed copy of the flag one enabled cycle later. A single valid output shows that an enabled cycle has just produced new results.

Top module: `sdi_sync_bits`

## Requirements
- R1: While reset is high and after reset is released, before the first enabled cycle, both word outputs, both flag outputs and `out_valid` are zero.
- R2: Each path updates its outputs only on a clock edge where `ce` is high, with a latency of exactly one enabled cycle. On edges where `ce` is low, the outputs hold and the word and flag inputs are ignored. `out_valid` is high exactly in the cycle after an edge with `ce` high.
- R3: Positions are counted per path.
  - A high flag on an enabled word makes that word position 0, including when a flag arrives inside a running window.
  - The following enabled words take positions 1 to 23.
  - Positions 0 to 7 form the ones group, 8 to 15 the first zeros group, and 16 to 23 the second zeros group.
- R4: On transmit, a word equal to 0x3FF at positions 0 to 6 is sent as 0x3FD. At position 7, the last luma word, it is sent unchanged.
- R5: On transmit, a word equal to 0x000 at positions 8 and 9 is kept. At positions 10 to 23 it is sent as 0x002.
- R6: Each path passes every other word unchanged. This covers words outside the 24-word window (including XYZ words, even when they equal 0x000 or 0x3FF) and window words whose value does not match the replaced pattern.
- R7: On receive, 0x3FD at positions 0 to 6 becomes 0x3FF, and 0x002 at positions 10 to 23 becomes 0x000. The same values at any other position pass unchanged.
- R8: Feeding the transmit output and flag into the receive inputs returns the original transmit input word for every enabled word.
- R9: With video words in 0x004..0x3FB and XYZ words with bit 9 set and bits 1:0 clear, the transmit output, serialized LSB first over enabled words, never has more than 18 consecutive ones or 21 consecutive zeros.
- R10: Each flag output equals the flag input of the previous enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Clock enable; one word per enabled edge |
| tx_word | input | 10 | Transmit word before sync-bit insertion |
| tx_trs | input | 1 | High on the first word of each TRS (transmit) |
| tx_out | output | 10 | Transmit word after insertion |
| tx_trs_out | output | 1 | Delayed transmit TRS flag |
| rx_word | input | 10 | Receive word carrying inserted sync bits |
| rx_trs | input | 1 | High on the first word of each TRS (receive) |
| rx_out | output | 10 | Receive word with preamble restored |
| rx_trs_out | output | 1 | Delayed receive TRS flag |
| out_valid | output | 1 | High after an enabled edge |

## Verification
The embedded properties check the following on every cycle:
- the hold of both paths while `ce` is low;
- the valid timing and the flag delay;
- that a flagged word starts at position 0;
- each substitution and pass-through rule, relating the registered output to the previous input and its position class.

Several behaviours are properties of whole sequences, and only the bench scenarios can show them:
- correct position counting across windows, restarts and enable gaps;
- the exact round trip through both paths;
- the bounds on serial run lengths.

// File: rtl/sdi_sb_pkg.sv
package sdi_sb_pkg;

  // Role of the current word inside a TRS preamble window
  typedef enum logic [2:0] {
    CLS_PASS      = 3'd0,  // outside the window
    CLS_ONES_SUB  = 3'd1,  // ones group, replaceable
    CLS_ONES_KEEP = 3'd2,  // last ones word, kept for framing
    CLS_ZERO_KEEP = 3'd3,  // leading zeros words, kept for framing
    CLS_ZERO_SUB  = 3'd4   // remaining zeros words, replaceable
  } pos_cls_e;

endpackage

// File: rtl/sb_trs_tracker.sv
module sb_trs_tracker
  import sdi_sb_pkg::*;
#(
  parameter int GRP  = 8,
  parameter int NGRP = 3,
  parameter int KEEP = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ce,
  input  logic     trs,
  output pos_cls_e cls
);

  localparam int TOTAL = GRP * NGRP;
  localparam int CW    = $clog2(TOTAL);

  logic [CW-1:0] cnt;
  logic          act;
  logic [CW-1:0] cur;

  always_comb cur = trs ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (ce) begin
      if (trs) begin
        act <= 1'b1;
        cnt <= CW'(1);
      end else if (act) begin
        if (cnt == CW'(TOTAL - 1)) begin
          act <= 1'b0;
          cnt <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    if (!(trs || act))                  cls = CLS_PASS;
    else if (cur <  CW'(GRP - 1))       cls = CLS_ONES_SUB;
    else if (cur == CW'(GRP - 1))       cls = CLS_ONES_KEEP;
    else if (cur <  CW'(GRP + KEEP))    cls = CLS_ZERO_KEEP;
    else                                cls = CLS_ZERO_SUB;
  end

  // R3: a flagged word always sits at the head of the ones group
  a_r3_flag_is_head: assert property (@(posedge clk) disable iff (rst)
    (ce && trs) |-> (cls == CLS_ONES_SUB));

endmodule

// File: rtl/sb_word_map.sv
module sb_word_map
  import sdi_sb_pkg::*;
#(
  parameter int W      = 10,
  parameter bit INSERT = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] word,
  input  logic         trs,
  input  pos_cls_e     cls,
  output logic [W-1:0] out_word,
  output logic         out_trs
);

  localparam logic [W-1:0] ALL1     = {W{1'b1}};
  localparam logic [W-1:0] ALL0     = '0;
  localparam logic [W-1:0] MARK     = W'(2);
  localparam logic [W-1:0] ONES_ALT = ALL1 & ~MARK;

  logic [W-1:0] mapped;

  generate
    if (INSERT) begin : g_ins
      always_comb begin
        mapped = word;
        case (cls)
          CLS_ONES_SUB: if (word == ALL1) mapped = ONES_ALT;
          CLS_ZERO_SUB: if (word == ALL0) mapped = MARK;
          default: ;
        endcase
      end

      // R4: replaceable ones words leave as the altered code
      a_r4_ones_alt: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ONES_SUB && word == ALL1) |=> (out_word == ONES_ALT));
      // R4: last ones word kept intact
      a_r4_last_kept: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ONES_KEEP) |=> (out_word == $past(word)));
      // R5: framing zeros kept, the rest marked
      a_r5_zero_kept: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ZERO_KEEP) |=> (out_word == $past(word)));
      a_r5_zero_mark: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ZERO_SUB && word == ALL0) |=> (out_word == MARK));
    end else begin : g_rem
      always_comb begin
        mapped = word;
        case (cls)
          CLS_ONES_SUB: if (word == ONES_ALT) mapped = ALL1;
          CLS_ZERO_SUB: if (word == MARK)     mapped = ALL0;
          default: ;
        endcase
      end

      // R7: restoration only in the matching positions
      a_r7_ones_back: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ONES_SUB && word == ONES_ALT) |=> (out_word == ALL1));
      a_r7_zero_back: assert property (@(posedge clk) disable iff (rst)
        (ce && cls == CLS_ZERO_SUB && word == MARK) |=> (out_word == ALL0));
      a_r7_keep_pos: assert property (@(posedge clk) disable iff (rst)
        (ce && (cls == CLS_ONES_KEEP || cls == CLS_ZERO_KEEP)) |=> (out_word == $past(word)));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_word <= '0;
      out_trs  <= 1'b0;
    end else if (ce) begin
      out_word <= mapped;
      out_trs  <= trs;
    end
  end

  // R2: outputs frozen while the enable is low
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(out_word) && $stable(out_trs)));
  // R6: words outside the window pass unchanged
  a_r6_outside: assert property (@(posedge clk) disable iff (rst)
    (ce && cls == CLS_PASS) |=> (out_word == $past(word)));
  // R10: flag delayed by one enabled cycle
  a_r10_flag_delay: assert property (@(posedge clk) disable iff (rst)
    ce |=> (out_trs == $past(trs)));

endmodule

// File: rtl/sdi_sync_bits.sv
module sdi_sync_bits
  import sdi_sb_pkg::*;
#(
  parameter int W    = 10,
  parameter int GRP  = 8,
  parameter int NGRP = 3,
  parameter int KEEP = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] tx_word,
  input  logic         tx_trs,
  output logic [W-1:0] tx_out,
  output logic         tx_trs_out,
  input  logic [W-1:0] rx_word,
  input  logic         rx_trs,
  output logic [W-1:0] rx_out,
  output logic         rx_trs_out,
  output logic         out_valid
);

  pos_cls_e tx_cls;
  pos_cls_e rx_cls;

  sb_trs_tracker #(.GRP(GRP), .NGRP(NGRP), .KEEP(KEEP)) u_tx_pos (
    .clk(clk), .rst(rst), .ce(ce), .trs(tx_trs), .cls(tx_cls)
  );

  sb_word_map #(.W(W), .INSERT(1'b1)) u_tx_map (
    .clk(clk), .rst(rst), .ce(ce), .word(tx_word), .trs(tx_trs), .cls(tx_cls),
    .out_word(tx_out), .out_trs(tx_trs_out)
  );

  sb_trs_tracker #(.GRP(GRP), .NGRP(NGRP), .KEEP(KEEP)) u_rx_pos (
    .clk(clk), .rst(rst), .ce(ce), .trs(rx_trs), .cls(rx_cls)
  );

  sb_word_map #(.W(W), .INSERT(1'b0)) u_rx_map (
    .clk(clk), .rst(rst), .ce(ce), .word(rx_word), .trs(rx_trs), .cls(rx_cls),
    .out_word(rx_out), .out_trs(rx_trs_out)
  );

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= ce;
  end

  // R2: valid follows the enable by one edge
  a_r2_valid_hi: assert property (@(posedge clk) disable iff (rst) ce |=> out_valid);
  a_r2_valid_lo: assert property (@(posedge clk) disable iff (rst) !ce |=> !out_valid);

endmodule

// File: tb/test_sdi_sync_bits.sv
`timescale 1ns/1ps
module test_sdi_sync_bits;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ce = 1'b0;
  logic [9:0] tx_word = '0;
  logic       tx_trs = 1'b0;
  logic [9:0] rx_word = '0;
  logic       rx_trs = 1'b0;
  logic [9:0] tx_out, rx_out;
  logic       tx_trs_out, rx_trs_out, out_valid;

  int total = 0;
  int bad = 0;

  // Bench-side position models, -1 means outside a window
  int tx_pos = -1;
  int rx_pos = -1;
  logic [9:0] e_tx = '0, e_rx = '0;
  logic       e_ttr = 1'b0, e_rtr = 1'b0;

  // Round-trip and run-length bookkeeping
  logic [9:0] rt_prev = '0;
  bit         rt_have = 1'b0;
  bit         run_bit = 1'b0;
  int         run_len = 0;
  int         max_one = 0;
  int         max_zero = 0;

  always #2 clk = ~clk;

  sdi_sync_bits i_sdi_sync_bits (
    .clk(clk), .rst(rst), .ce(ce),
    .tx_word(tx_word), .tx_trs(tx_trs), .tx_out(tx_out), .tx_trs_out(tx_trs_out),
    .rx_word(rx_word), .rx_trs(rx_trs), .rx_out(rx_out), .rx_trs_out(rx_trs_out),
    .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int adv(input bit t, input int p);
    if (t) return 0;
    if (p >= 0 && p < 23) return p + 1;
    return -1;
  endfunction

  // R4, R5, R6
  function automatic logic [9:0] exp_tx(input logic [9:0] w, input int p);
    if (p >= 0 && p <= 6 && w == 10'h3FF) return 10'h3FD;
    if (p >= 10 && p <= 23 && w == 10'h000) return 10'h002;
    return w;
  endfunction

  // R7, R6
  function automatic logic [9:0] exp_rx(input logic [9:0] w, input int p);
    if (p >= 0 && p <= 6 && w == 10'h3FD) return 10'h3FF;
    if (p >= 10 && p <= 23 && w == 10'h002) return 10'h000;
    return w;
  endfunction

  task automatic step(input logic [9:0] tw, input bit tt, input logic [9:0] rw,
                      input bit rt, input bit en, input string tag);
    tx_word = tw; tx_trs = tt; rx_word = rw; rx_trs = rt; ce = en;
    if (en) begin
      tx_pos = adv(tt, tx_pos);
      rx_pos = adv(rt, rx_pos);
      e_tx = exp_tx(tw, tx_pos);
      e_rx = exp_rx(rw, rx_pos);
      e_ttr = tt;
      e_rtr = rt;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " tx word"}, tx_out, e_tx);
    check({tag, " rx word"}, rx_out, e_rx);
    check("R10 tx flag", {9'd0, tx_trs_out}, {9'd0, e_ttr});
    check("R10 rx flag", {9'd0, rx_trs_out}, {9'd0, e_rtr});
    check("R2 valid", {9'd0, out_valid}, {9'd0, en});
  endtask

  // Transmit output looped into the receive input
  task automatic rt_step(input logic [9:0] w, input bit t, input bit en);
    logic [9:0] lw;
    bit lt;
    lw = tx_out;
    lt = tx_trs_out;
    if (!en) begin
      step(10'($urandom), 1'($urandom), 10'($urandom), 1'($urandom), 1'b0, "R2 idle");
    end else begin
      step(w, t, lw, lt, 1'b1, "R6 stream");
      if (rt_have) check("R8 round trip", rx_out, rt_prev);
      rt_prev = w;
      rt_have = 1'b1;
      for (int b = 0; b < 10; b++) begin
        if (tx_out[b] == run_bit) run_len++;
        else begin
          run_bit = tx_out[b];
          run_len = 1;
        end
        if (run_bit && run_len > max_one) max_one = run_len;
        if (!run_bit && run_len > max_zero) max_zero = run_len;
      end
    end
  endtask

  task automatic rt_word(input logic [9:0] w, input bit t);
    while ($urandom_range(0, 3) == 0) rt_step(10'd0, 1'b0, 1'b0);
    rt_step(w, t, 1'b1);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [9:0] xyz;
    void'($urandom(32'd4711));

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 tx word", tx_out, 10'h000);
    check("R1 rx word", rx_out, 10'h000);
    check("R1 valid", {9'd0, out_valid}, 10'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", tx_out, 10'h000);

    // R4 R5 R6 R7: full preamble on both paths, plus 0x000 XYZ words outside
    for (int i = 0; i < 32; i++) begin
      logic [9:0] w;
      w = (i < 8) ? 10'h3FF : (i < 24) ? 10'h000 : 10'h000;
      step(w, i == 0, exp_tx(w, i < 24 ? i : -1), i == 0, 1'b1,
           i < 8 ? "R4 ones" : i < 24 ? "R5 zeros" : "R6 xyz");
    end

    // R6: preamble codes outside any window
    step(10'h3FF, 1'b0, 10'h3FD, 1'b0, 1'b1, "R6 outside");
    step(10'h000, 1'b0, 10'h002, 1'b0, 1'b1, "R6 outside");

    // R2: garbage while disabled must not move anything
    step(10'h3FF, 1'b1, 10'h002, 1'b1, 1'b0, "R2 disabled");
    step(10'h000, 1'b1, 10'h3FD, 1'b1, 1'b0, "R2 disabled");
    step(10'h3FF, 1'b0, 10'h3FD, 1'b0, 1'b1, "R2 flag ignored");

    // R3: restart inside a window; R6 mismatching value inside window
    for (int i = 0; i < 5; i++) step(10'h3FF, i == 0, 10'h3FD, i == 0, 1'b1, "R3 pre");
    step(10'h155, 1'b0, 10'h155, 1'b0, 1'b1, "R6 mismatch");
    for (int i = 0; i < 12; i++) step(i < 8 ? 10'h3FF : 10'h000, i == 0,
                                      i < 8 ? 10'h3FD : 10'h002, i == 0, 1'b1, "R3 restart");

    // R7: codes in kept positions stay on receive
    for (int i = 0; i < 12; i++) step(10'h200, i == 0,
                                      i == 7 ? 10'h3FD : (i == 8 || i == 9) ? 10'h002 : 10'h100,
                                      i == 0, 1'b1, "R7 kept pos");
    for (int i = 0; i < 16; i++) step(10'h200, 1'b0, 10'h200, 1'b0, 1'b1, "R6 flush");

    // R8 R9: random video lines with embedded TRS, looped through both paths
    run_len = 0;
    max_one = 0;
    max_zero = 0;
    for (int ln = 0; ln < 60; ln++) begin
      int nv;
      nv = $urandom_range(10, 50);
      for (int v = 0; v < nv; v++) rt_word(10'($urandom_range(4, 1019)), 1'b0);
      xyz = {1'b1, 7'($urandom), 2'b00};
      for (int i = 0; i < 24; i++) rt_word(i < 8 ? 10'h3FF : 10'h000, i == 0);
      for (int i = 0; i < 8; i++) rt_word(xyz, 1'b0);
    end
    rt_word(10'h200, 1'b0);

    total++;
    if (max_one > 18) begin
      bad++;
      $display("FAIL R9 ones run actual=%0d expected<=18", max_one);
    end
    total++;
    if (max_zero > 21) begin
      bad++;
      $display("FAIL R9 zeros run actual=%0d expected<=21", max_zero);
    end

    finish_run();
  end

endmodule